// File: doc/BRIEF.md
# Receive CRC Error Statistics Counter

This block keeps a running total of received Ethernet frames whose frame check sequence was found to be wrong. The receive path supplies one end-of-frame strobe per frame. With that strobe come the frame's byte length, a flag for a bad checksum and a flag for whether the destination address filter accepted the frame. A frame adds one to the total only when three conditions hold: its checksum is bad, it passed the filter, and it is at least the minimum legal length. That length is counted from the first destination address byte through the last checksum byte.

Software reads the total through a single-cycle read strobe. The read returns the value and clears the counter in the same access. The counter does not wrap: once it reaches all ones it stays there until a read or a reset. If a qualifying frame and a read land on the same counter update, the read returns the old total and the counter restarts at one, so no event is lost.

The counter is a small state machine with three states. `ST_EMPTY` means the count is zero, `ST_RUN` means it is between one and all ones minus one, and `ST_FULL` means it is saturated at all ones. An increment moves `ST_EMPTY` to `ST_RUN`, stays in `ST_RUN`, and moves `ST_RUN` to `ST_FULL` when it completes the last step. An increment leaves `ST_FULL` where it is. A read with no increment takes every state to `ST_EMPTY`. A read together with an increment takes every state to `ST_RUN`, with the count at one.

Top module: `rx_fcs_err_stat`

## Requirements
- R1: After the synchronous active-high reset, the counter is zero and the read data output is zero. A read issued straight after reset returns 0.
- R2: A frame is qualifying when, at its end-of-frame strobe, crc_bad=1, addr_match=1 and frame_len>=64. Each qualifying frame adds exactly one to the count, including frames whose strobes fall on consecutive cycles.
- R3: A frame whose frame_len is 63 or less is not counted, even if its CRC is bad and its address matched. A frame with frame_len of exactly 64 is counted.
- R4: A frame with addr_match=0 leaves the count unchanged.
- R5: A frame with crc_bad=0 leaves the count unchanged.
- R6: A read strobe updates rd_data on that clock edge with the count held before the edge, and clears the count. A second read with no events in between returns 0.
- R7: If a read strobe coincides with the counter applying an increment, rd_data returns the old count and the counter becomes 1.
- R8: The count saturates at all ones (CNT_W bits). Further qualifying frames leave it at all ones. The next read returns all ones, and the read after that returns 0.
- R9: A qualifying frame is visible to a read strobe issued on the second clock edge after the edge that samples its end-of-frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| eof_stb | input | 1 | One-cycle end-of-frame strobe |
| frame_len | input | LEN_W (16) | Frame byte length, destination address through CRC |
| crc_bad | input | 1 | The frame's CRC check failed |
| addr_match | input | 1 | The frame passed destination address filtering |
| rd_stb | input | 1 | Read-and-clear strobe |
| rd_data | output | CNT_W (32) | Count captured by the most recent read |

## Verification
The end-of-frame strobe is registered in the qualifier on edge k. The counter applies the increment on edge k+1. A read strobe on edge k+2 captures the new total into rd_data, and rd_data is sampled at the falling edge that follows. The bench therefore leaves one idle cycle between a frame and its read for every vector and for the R9 check. For R7 it places the read on edge k+1 on purpose, so that the read meets the increment. A further read two cycles later then confirms the restart value of 1.

// File: rtl/crcstat_pkg.sv
package crcstat_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_RUN   = 2'd1,
        ST_FULL  = 2'd2
    } cnt_state_e;

    localparam int STAT_W_DEF  = 32;
    localparam int LEN_W_DEF   = 16;
    localparam int MIN_LEN_DEF = 64;

endpackage

// File: rtl/crcstat_qualifier.sv
module crcstat_qualifier #(
    parameter int LEN_W   = crcstat_pkg::LEN_W_DEF,
    parameter int MIN_LEN = crcstat_pkg::MIN_LEN_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eof_stb,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             crc_bad,
    input  logic             addr_match,
    output logic             evt_q
);

    localparam logic [LEN_W-1:0] LEN_FLOOR = LEN_W'(MIN_LEN);

    logic long_enough;
    logic evt_d;

    always_comb begin
        long_enough = (frame_len >= LEN_FLOOR);
        evt_d       = eof_stb && crc_bad && addr_match && long_enough;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= evt_d;
        end
    end

    // R4
    no_miss_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (eof_stb && !addr_match) |=> !evt_q);

    // R5
    no_good_crc_chk: assert property (@(posedge clk) disable iff (rst)
        (eof_stb && !crc_bad) |=> !evt_q);

    // R3
    no_runt_chk: assert property (@(posedge clk) disable iff (rst)
        (eof_stb && (frame_len < LEN_FLOOR)) |=> !evt_q);

endmodule

// File: rtl/crcstat_sat_counter.sv
module crcstat_sat_counter #(
    parameter int CNT_W = crcstat_pkg::STAT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             rd,
    output logic [CNT_W-1:0] rd_data
);
    import crcstat_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_EDGE = {{(CNT_W-1){1'b1}}, 1'b0};

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and next-count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rd) begin
            cnt_d   = inc ? CNT_ONE : '0;
            state_d = inc ? ST_RUN : ST_EMPTY;
        end else if (inc) begin
            unique case (state_q)
                ST_EMPTY: begin
                    cnt_d   = CNT_ONE;
                    state_d = ST_RUN;
                end
                ST_RUN: begin
                    cnt_d = cnt_q + CNT_ONE;
                    if (cnt_q == CNT_EDGE) begin
                        state_d = ST_FULL;
                    end
                end
                ST_FULL: begin
                    cnt_d = CNT_MAX;
                end
                default: begin
                    cnt_d   = '0;
                    state_d = ST_EMPTY;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // read output register
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd) begin
            rd_data <= cnt_q;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !rd) |=> cnt_q == CNT_MAX);

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !rd && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_ONE);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !inc) |=> (cnt_q == '0 && state_q == ST_EMPTY));

    // R7
    collide_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && inc) |=> (cnt_q == CNT_ONE && rd_data == $past(cnt_q)));

    // R8
    full_state_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL) |-> (cnt_q == CNT_MAX));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !rd) |=> $stable(cnt_q));

endmodule

// File: rtl/rx_fcs_err_stat.sv
module rx_fcs_err_stat #(
    parameter int CNT_W   = crcstat_pkg::STAT_W_DEF,
    parameter int LEN_W   = crcstat_pkg::LEN_W_DEF,
    parameter int MIN_LEN = crcstat_pkg::MIN_LEN_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eof_stb,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             crc_bad,
    input  logic             addr_match,
    input  logic             rd_stb,
    output logic [CNT_W-1:0] rd_data
);

    logic qual_evt;

    crcstat_qualifier #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) i_qual (
        .clk        (clk),
        .rst        (rst),
        .eof_stb    (eof_stb),
        .frame_len  (frame_len),
        .crc_bad    (crc_bad),
        .addr_match (addr_match),
        .evt_q      (qual_evt)
    );

    crcstat_sat_counter #(
        .CNT_W (CNT_W)
    ) i_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (qual_evt),
        .rd      (rd_stb),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_rx_fcs_err_stat.sv
module test_rx_fcs_err_stat;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eof_stb = 1'b0;
    logic [15:0] frame_len = '0;
    logic        crc_bad = 1'b0;
    logic        addr_match = 1'b0;
    logic        rd_stb = 1'b0;
    logic        n_rd_stb = 1'b0;
    logic [31:0] rd_data;
    logic [3:0]  n_rd_data;

    int applied = 0;
    int miscompares = 0;

    always #(CLK_NS/2) clk = ~clk;

    rx_fcs_err_stat i_rx_fcs_err_stat (
        .clk(clk), .rst(rst), .eof_stb(eof_stb), .frame_len(frame_len),
        .crc_bad(crc_bad), .addr_match(addr_match), .rd_stb(rd_stb),
        .rd_data(rd_data)
    );

    rx_fcs_err_stat #(.CNT_W(4)) i_rx_fcs_err_stat_narrow (
        .clk(clk), .rst(rst), .eof_stb(eof_stb), .frame_len(frame_len),
        .crc_bad(crc_bad), .addr_match(addr_match), .rd_stb(n_rd_stb),
        .rd_data(n_rd_data)
    );

    // {len[15:0], crc_bad, addr_match, expected count}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {16'd64,   1'b1, 1'b1, 1'b1},
        {16'd63,   1'b1, 1'b1, 1'b0},
        {16'd1518, 1'b1, 1'b1, 1'b1},
        {16'd100,  1'b1, 1'b0, 1'b0},
        {16'd100,  1'b0, 1'b1, 1'b0},
        {16'd0,    1'b1, 1'b1, 1'b0},
        {16'd65,   1'b1, 1'b1, 1'b1},
        {16'd64,   1'b0, 1'b0, 1'b0},
        {16'hFFFF, 1'b1, 1'b1, 1'b1},
        {16'd40,   1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] len, input logic bad, input logic am);
        eof_stb = 1'b1; frame_len = len; crc_bad = bad; addr_match = am;
        @(negedge clk);
        eof_stb = 1'b0; crc_bad = 1'b0; addr_match = 1'b0; frame_len = '0;
    endtask

    task automatic do_read(output logic [31:0] v);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic do_nread(output logic [3:0] v);
        n_rd_stb = 1'b1;
        @(negedge clk);
        n_rd_stb = 1'b0;
        v = n_rd_data;
    endtask

    initial begin
        #(CLK_NS * 200000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [3:0]  nv;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check("R1", rd_data, 32'd0);
        do_read(v);
        check("R1", v, 32'd0);

        // table walk: R2 R3 R4 R5 R9
        for (int k = 0; k < NV; k++) begin
            frame(VEC[k][18:3], VEC[k][2], VEC[k][1]);
            idle(1);
            do_read(v);
            check("R2/R3/R4/R5/R9", v, {31'd0, VEC[k][0]});
        end

        // R2 back-to-back frames
        for (int k = 0; k < 5; k++) frame(16'd200, 1'b1, 1'b1);
        idle(1);
        do_read(v);
        check("R2", v, 32'd5);

        // R6 read clears
        do_read(v);
        check("R6", v, 32'd0);

        // R7 collision: three counted, then a frame whose increment meets a read
        for (int k = 0; k < 3; k++) frame(16'd64, 1'b1, 1'b1);
        idle(1);
        frame(16'd64, 1'b1, 1'b1);
        do_read(v);
        check("R7", v, 32'd3);
        idle(1);
        do_read(v);
        check("R7", v, 32'd1);

        // R8 saturation on narrow instance
        do_nread(nv);
        idle(1);
        do_nread(nv);
        check("R8", {28'd0, nv}, 32'd0);
        for (int k = 0; k < 20; k++) frame(16'd64, 1'b1, 1'b1);
        idle(1);
        do_nread(nv);
        check("R8", {28'd0, nv}, 32'd15);
        do_nread(nv);
        check("R8", {28'd0, nv}, 32'd0);

        // R1 reset mid-count
        do_read(v);
        frame(16'd64, 1'b1, 1'b1);
        idle(1);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        check("R1", rd_data, 32'd0);
        do_read(v);
        check("R1", v, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule